// File: doc/BRIEF.md
# Pipelined Microprogrammed Control Unit

This block sequences a microprogram held in its own writable store and issues one microinstruction per clock to an external data path. Every stored word has four fields. A next-step operation chooses how the next address is formed. A branch target gives the address to jump to. A condition selector picks one of the incoming condition-code bits. The remaining bits are data-path control, which leave the block on `ctrl_out`.

A pipeline register sits on the output of the store. The word held in that register drives the data path and steers the sequencer in the same cycle. Meanwhile the store is already reading the word the sequencer has just chosen. Because fetch overlaps execution, the cycle time is set by the slower of the two rather than by their sum, and no path runs combinationally from a branch field through the store and back into the sequencer. A branch takes effect on the very next issued word: no word after a branch in the store slips through as a delay slot.

The sequencer is treated as a four-state decision made each cycle on the issued word's operation: STEP, which goes on to the sequential address; ZERO, which restarts at address 0; JUMP, which goes to the branch target; and TEST, which goes to the target when the selected condition bit is 1 and otherwise steps on. After every fetch the internal address counter becomes the fetched address plus one, whichever of the four transitions produced it. The store is loaded through a write port that is honoured only while reset is held.

Top module: `ucu_ctrl`

## Requirements
- R1: While `rst_n` is low, `ctrl_out` is 0 and `fetch_addr` is 0. The first word issued after reset release is the one at address 0, one cycle after release.
- R2: When the issued word's operation is STEP (code 0), `fetch_addr` equals the previously fetched address plus one, modulo the store depth.
- R3: When the issued word's operation is ZERO (code 1), `fetch_addr` is 0.
- R4: When the issued word's operation is JUMP (code 2), `fetch_addr` is the word's branch target, and the word stored after the jump is not issued.
- R5: When the issued word's operation is TEST (code 3) and the selected condition bit is 1, `fetch_addr` is the branch target.
- R6: When the issued word's operation is TEST (code 3) and the selected condition bit is 0, `fetch_addr` is the previously fetched address plus one.
- R7: The 2-bit condition selector value s picks `cc_in[s]` for every s from 0 to 3.
- R8: The word stored at `fetch_addr` in one cycle is issued after the next rising edge, and its low CTRL_W bits drive `ctrl_out` for that whole cycle. Word layout, from the MSB: operation [17:16], branch target [15:10], condition selector [9:8], control [7:0].
- R9: A store write (`ld_en` high, word at `ld_addr`) takes effect at a rising edge only while `rst_n` is low. With `rst_n` high, `ld_en` has no effect on any later issued word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables store loading |
| cc_in | input | 4 | Condition-code bits from the data path |
| ld_en | input | 1 | Store write enable (honoured only while in reset) |
| ld_addr | input | 6 | Store write address |
| ld_data | input | 18 | Store write word |
| fetch_addr | output | 6 | Address being read from the store this cycle |
| ctrl_out | output | 8 | Control field of the issued microinstruction |

## Verification
A wrong address counter shows on `fetch_addr` in the same cycle. One edge later it shows on `ctrl_out` as the control field of the wrong word. A corrupted pipeline register or a wrong condition multiplexer shows within one cycle: either as a wrong `ctrl_out`, or as a branch that goes the wrong way. Because every word carries a distinct control value, one wrong fetch is enough to make the whole later trace diverge from the expected address and control sequence. A write that leaks in during running shows the next time that address is reached.

// File: rtl/ucu_pkg.sv
`timescale 1ns/1ps
package ucu_pkg;

    localparam int OP_W = 2;

    // next-step operation carried in the top field of every word
    typedef enum logic [OP_W-1:0] {
        OP_STEP = 2'd0,
        OP_ZERO = 2'd1,
        OP_JUMP = 2'd2,
        OP_TEST = 2'd3
    } op_e;

endpackage

// File: rtl/ucu_store.sv
`timescale 1ns/1ps
module ucu_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // asynchronous read: the pipeline register downstream breaks the loop
    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/ucu_seq.sv
`timescale 1ns/1ps
module ucu_seq
    import ucu_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int CC_N         = 4,
    parameter bit CC_LAST_TRUE = 1'b0,
    localparam int SEL_W = $clog2(CC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] target,
    input  logic [SEL_W-1:0]  cc_sel,
    input  logic [CC_N-1:0]   cc_in,
    output logic [ADDR_W-1:0] fetch_addr
);

    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] nxt;
    logic              cc_bit;
    logic              run_q;

    // condition multiplexer; one variant ties the last select to true
    generate
        if (CC_LAST_TRUE) begin : g_cc_tied
            always_comb begin
                cc_bit = (cc_sel == SEL_W'(CC_N - 1)) ? 1'b1 : cc_in[cc_sel];
            end
        end else begin : g_cc_plain
            always_comb begin
                cc_bit = cc_in[cc_sel];
            end
        end
    endgenerate

    // transition choice: STEP, ZERO, JUMP, TEST
    always_comb begin
        unique case (op)
            OP_STEP: nxt = upc_q;
            OP_ZERO: nxt = '0;
            OP_JUMP: nxt = target;
            OP_TEST: nxt = cc_bit ? target : upc_q;
            default: nxt = upc_q;
        endcase
    end

    // counter register: always fetched address plus one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc_q <= '0;
            run_q <= 1'b0;
        end else begin
            upc_q <= nxt + 1'b1;
            run_q <= 1'b1;
        end
    end

    assign fetch_addr = nxt;

    p_step_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && op == OP_STEP) |-> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

    p_zero_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ZERO) |=> upc_q == ADDR_W'(1));

    p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP) |=> upc_q == ADDR_W'($past(target) + 1'b1));

    p_test_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TEST && cc_bit) |=> upc_q == ADDR_W'($past(target) + 1'b1));

    p_test_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && op == OP_TEST && !cc_bit) |-> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

endmodule

// File: rtl/ucu_pipe.sv
`timescale 1ns/1ps
module ucu_pipe #(
    parameter int                WORD_W   = 18,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= NOP_WORD;
        end else begin
            q <= d;
        end
    end

    p_nop_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> q == NOP_WORD);

endmodule

// File: rtl/ucu_ctrl.sv
`timescale 1ns/1ps
module ucu_ctrl
    import ucu_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int CTRL_W       = 8,
    parameter int CC_N         = 4,
    parameter bit CC_LAST_TRUE = 1'b0,
    localparam int SEL_W  = $clog2(CC_N),
    localparam int WORD_W = OP_W + ADDR_W + SEL_W + CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CC_N-1:0]   cc_in,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [CTRL_W-1:0] ctrl_out
);

    localparam int SEL_LSB = CTRL_W;
    localparam int TGT_LSB = SEL_LSB + SEL_W;
    localparam int OP_LSB  = TGT_LSB + ADDR_W;
    localparam logic [WORD_W-1:0] NOP_WORD = '0;  // STEP with zero control

    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] issued;
    logic              wr_ok;
    op_e               op;

    // loading is honoured only while the controller is held in reset
    assign wr_ok = ld_en & ~rst_n;

    ucu_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (fetch_addr),
        .rd_data (rd_word)
    );

    ucu_pipe #(.WORD_W(WORD_W), .NOP_WORD(NOP_WORD)) pipe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rd_word),
        .q     (issued)
    );

    assign op = op_e'(issued[OP_LSB +: OP_W]);

    ucu_seq #(.ADDR_W(ADDR_W), .CC_N(CC_N), .CC_LAST_TRUE(CC_LAST_TRUE)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .target     (issued[TGT_LSB +: ADDR_W]),
        .cc_sel     (issued[SEL_LSB +: SEL_W]),
        .cc_in      (cc_in),
        .fetch_addr (fetch_addr)
    );

    assign ctrl_out = issued[CTRL_W-1:0];

    p_issue_follows_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ctrl_out == $past(rd_word[CTRL_W-1:0]));

endmodule

// File: tb/ucu_ctrl_tb_top.sv
`timescale 1ns/1ps
module ucu_ctrl_tb_top;

    localparam int AW = 6;
    localparam int CW = 8;
    localparam int NC = 4;
    localparam int SW = 2;
    localparam int WW = 2 + AW + SW + CW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] cc_in = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [WW-1:0] ld_data = '0;
    logic [AW-1:0] fetch_addr;
    logic [CW-1:0] ctrl_out;

    always #2.5 clk = ~clk;

    ucu_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cc_in(cc_in), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .fetch_addr(fetch_addr), .ctrl_out(ctrl_out)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [CW-1:0] c;
        string         t;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_on = 1'b0;
    logic [WW-1:0] prog [DEPTH];

    // R8 layout: op[17:16] target[15:10] sel[9:8] ctrl[7:0]
    function automatic logic [WW-1:0] mk(input logic [1:0] op, input int tgt,
                                         input int sel, input int ctl);
        return {op, AW'(tgt), SW'(sel), CW'(ctl)};
    endfunction

    // reference model built from the requirements
    task automatic build(input logic [NC-1:0] cc, input int n);
        logic [WW-1:0] w;
        logic [AW-1:0] pc;
        logic [AW-1:0] a;
        logic [1:0] op;
        logic [AW-1:0] tg;
        logic [SW-1:0] sl;
        string tag;
        w = '0;
        pc = '0;
        for (int k = 0; k < n; k++) begin
            op = w[WW-1 -: 2];
            tg = w[CW+SW +: AW];
            sl = w[CW +: SW];
            case (op)
                2'd0: begin a = pc; tag = (k == 0) ? "R1 R8" : "R2 R8"; end
                2'd1: begin a = '0; tag = "R3"; end
                2'd2: begin a = tg; tag = "R4"; end
                default: begin
                    if (cc[sl]) begin a = tg; tag = "R5 R7"; end
                    else        begin a = pc; tag = "R6 R7"; end
                end
            endcase
            exp_q.push_back('{a: a, c: w[CW-1:0], t: tag});
            w = prog[a];
            pc = a + 1'b1;
        end
    endtask

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (fetch_addr !== e.a || ctrl_out !== e.c) begin
                errors++;
                $display("FAIL %s: addr=%0d ctrl=%0h, expected addr=%0d ctrl=%0h",
                         e.t, fetch_addr, ctrl_out, e.a, e.c);
            end
        end
    end

    task automatic check_reset_outs(input string why);
        @(negedge clk);
        checks++;
        if (ctrl_out !== '0 || fetch_addr !== '0) begin
            errors++;
            $display("FAIL R1 %s: addr=%0d ctrl=%0h, expected 0 and 0", why, fetch_addr, ctrl_out);
        end
    endtask

    task automatic run(input logic [NC-1:0] cc, input int n, input bit poke);
        cc_in = cc;
        build(cc, n);
        @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        if (poke) begin
            // R9: write attempt while running must not alter the store
            repeat (5) @(posedge clk);
            #1 ld_en = 1'b1; ld_addr = AW'(13); ld_data = mk(2'd1, 0, 0, 8'hEE);
            @(posedge clk);
            #1 ld_en = 1'b0;
        end
        while (exp_q.size() != 0) @(posedge clk);
        #1 mon_on = 1'b0;
        rst_n = 1'b0;
        check_reset_outs("async reset mid-run");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) prog[i] = mk(2'd0, 0, 0, i + 1);
        prog[1]  = mk(2'd2, 8, 0, 2);    // JUMP over word 2
        prog[8]  = mk(2'd3, 12, 0, 9);   // TEST cc0
        prog[12] = mk(2'd3, 20, 1, 13);  // TEST cc1
        prog[13] = mk(2'd3, 16, 2, 14);  // TEST cc2
        prog[16] = mk(2'd3, 30, 3, 17);  // TEST cc3
        prog[17] = mk(2'd1, 0, 0, 18);   // ZERO

        repeat (2) @(posedge clk);
        check_reset_outs("initial reset");
        for (int i = 0; i < DEPTH; i++) begin
            @(posedge clk);
            #1 ld_en = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
        end
        @(posedge clk);
        #1 ld_en = 1'b0;
        check_reset_outs("after load");

        run(4'b0101, 22, 1'b1);
        run(4'b1010, 26, 1'b0);
        run(4'b1111, 18, 1'b0);
        run(4'b0101, 22, 1'b0);   // R9: word 13 still the original TEST

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule